// File: doc/BRIEF.md
# Host-Configured Reset Sequencer

This block decides when a processor subsystem leaves reset. It watches a synchronous, active-low power-on reset input. At the first clock edge after that input goes high, it samples a strap. A high strap means an external host must supply a 32-bit configuration word before anything else can start. The host delivers the word as four byte writes, all made to the same register, and the internal reset stays asserted until the last byte has landed. A low strap skips the host: the word comes from a parameter and the internal reset drops at once.

Once the word is valid, the sequencer waits for the PLL to report lock. If the DLL is in use, it then counts a fixed DLL settling window and requires the DLL lock as well. After that it holds the hard reset for a fixed number of bus clocks and releases it. The soft reset follows a fixed three clocks later. The lock inputs are levels. If a lock drops before the hard reset is released, the matching wait starts again.

Top module: `hostcfg_reset_seq`

## Requirements
- R1: While `por_n` is sampled low at a clock edge, after that edge `int_rst`, `hard_rst` and `soft_rst` are 1, `cfg_valid` is 0 and `cfg_word` is 0. This holds at any time, including in the middle of a sequence.
- R2: `host_en_strap` is sampled only at the first edge where `por_n` is high after being low. Later changes to the strap have no effect until the next power-on reset.
- R3: With the strap sampled high, `int_rst` stays 1 through the first three accepted writes. It goes to 0 at the edge of the fourth write.
- R4: A write is a cycle with `cfg_wr`=1. The first accepted byte fills `cfg_word[7:0]`, the second fills [15:8], the third fills [23:16] and the fourth fills [31:24]. `cfg_valid` rises at the edge of the fourth write.
- R5: Writes made while `por_n` is low, and writes after the fourth one, leave `cfg_word` unchanged.
- R6: With the strap sampled high, 1 here meaning the host path is in use, the strap edge leaves `int_rst` at 1. With the strap sampled low, `int_rst` goes to 0 at the strap edge, `cfg_word` becomes `DEFAULT_CFG` and `cfg_valid` becomes 1. Host writes are then ignored.
- R7: Call E the first edge after the word is valid at which `pll_lock` is 1. With `dll_en`=1, and `dll_lock` high by then, `hard_rst` goes to 0 at edge E+3585 (3073 + 512).
- R8: With `dll_en`=0, `hard_rst` goes to 0 at edge E+512.
- R9: `soft_rst` goes to 0 exactly 3 edges after `hard_rst` goes to 0. It is never 0 while `hard_rst` is 1.
- R10: If `pll_lock` drops before `hard_rst` is released, the sequence goes back to waiting for PLL lock. The release is then timed from the next edge where the lock is high again.
- R11: With `dll_en`=1, a drop of `dll_lock` during the 512-cycle hold restarts the hold. `hard_rst` then goes to 0 at F+512, where F is the edge at which `dll_lock` is high again.
- R12: `pll_lock` has no effect until the configuration word is valid. The lock event E is the first edge after the word completes at which `pll_lock` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, sampled synchronously |
| host_en_strap | input | 1 | Selects the host configuration path when sampled high |
| cfg_wr | input | 1 | Host write strobe for the configuration register |
| cfg_wdata | input | 8 | Host write data byte |
| pll_lock | input | 1 | PLL lock level |
| dll_lock | input | 1 | DLL lock level |
| dll_en | input | 1 | DLL in use; adds the DLL window and the DLL lock check |
| int_rst | output | 1 | Internal power-on reset, active high |
| cfg_word | output | 32 | Assembled configuration word |
| cfg_valid | output | 1 | Configuration word complete |
| hard_rst | output | 1 | Hard reset, active high |
| soft_rst | output | 1 | Soft reset, active high |

## Verification
The bench measures the exact release edge in both DLL modes. An off-by-one in the counter limits, or counting from the wrong event, shows up as 3585 or 512 turning into a neighbouring value. It checks that the strap is latched only at the reset edge, that the byte order is least-significant first, and that a fifth write is dropped; a design that re-sampled the strap or kept accepting bytes would corrupt the word. It drops each lock in turn. It also raises PLL lock before configuration, which would start the count early in a design that failed to gate it. Finally, it asserts power-on reset in the middle of a sequence to confirm that every output returns to its reset value.

// File: rtl/hcrs_pkg.sv
package hcrs_pkg;

  typedef enum logic [1:0] {
    F_IDLE,
    F_CFG,
    F_DONE
  } front_t;

  typedef enum logic [2:0] {
    S_OFF,
    S_PLL,
    S_DLL,
    S_HOLD,
    S_GAP,
    S_RUN
  } seq_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // The DLL condition is satisfied when the DLL is not in use or reports lock.
  function automatic logic lock_ok(input logic dll_on, input logic dll_lock);
    return !dll_on || dll_lock;
  endfunction

  // Edges from the PLL lock event until the hard reset is released.
  function automatic int unsigned release_span(input logic dll_on,
                                               input int unsigned dll_wait,
                                               input int unsigned hold);
    return dll_on ? dll_wait + hold : hold;
  endfunction

endpackage

// File: rtl/hcrs_cfg_loader.sv
module hcrs_cfg_loader #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter logic [WORD_W-1:0] DEFAULT_CFG = '0
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              load_default,
  input  logic              wr_accept,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_valid,
  output logic              word_done
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [IDX_W-1:0] idx_q;
  logic             valid_q;

  assign word_done = wr_accept && (idx_q == IDX_W'(LANES - 1));
  assign cfg_valid = valid_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_default) begin
      valid_q <= 1'b1;
    end else if (wr_accept) begin
      idx_q <= idx_q + 1'b1;
      if (word_done) valid_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!por_n)
        lane_q <= '0;
      else if (load_default)
        lane_q <= DEFAULT_CFG[g*BYTE_W +: BYTE_W];
      else if (wr_accept && (idx_q == IDX_W'(g)))
        lane_q <= wr_data;
    end
    assign cfg_word[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/hcrs_release_seq.sv
module hcrs_release_seq
  import hcrs_pkg::*;
#(
  parameter int DLL_WAIT = 3073,
  parameter int HOLD_CYC = 512,
  parameter int GAP_CYC  = 3
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic pll_lock,
  input  logic dll_lock,
  input  logic dll_en,
  output logic hard_rst,
  output logic soft_rst
);
  localparam int unsigned MAXC = max2(max2(DLL_WAIT, HOLD_CYC), GAP_CYC);
  localparam int CW = $clog2(MAXC + 1);

  seq_t          st_q;
  logic [CW-1:0] cnt_q;
  logic          dll_on_q;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      st_q     <= S_OFF;
      cnt_q    <= '0;
      dll_on_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_OFF: if (start) st_q <= S_PLL;
        S_PLL: begin
          if (pll_lock) begin
            dll_on_q <= dll_en;
            cnt_q    <= CW'(1);
            st_q     <= dll_en ? S_DLL : S_HOLD;
          end
        end
        S_DLL: begin
          if (!pll_lock) begin
            st_q <= S_PLL;
          end else if (cnt_q == CW'(DLL_WAIT)) begin
            if (dll_lock) begin
              st_q  <= S_HOLD;
              cnt_q <= CW'(1);
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_HOLD: begin
          if (!pll_lock) begin
            st_q <= S_PLL;
          end else if (!lock_ok(dll_on_q, dll_lock)) begin
            cnt_q <= '0;
          end else if (cnt_q == CW'(HOLD_CYC)) begin
            st_q  <= S_GAP;
            cnt_q <= CW'(1);
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_GAP: begin
          if (cnt_q == CW'(GAP_CYC)) st_q <= S_RUN;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= S_RUN;
      endcase
    end
  end

  assign hard_rst = (st_q == S_OFF) || (st_q == S_PLL) || (st_q == S_DLL) || (st_q == S_HOLD);
  assign soft_rst = hard_rst || (st_q == S_GAP);

endmodule

// File: rtl/hostcfg_reset_seq.sv
module hostcfg_reset_seq
  import hcrs_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  parameter int DLL_WAIT = 3073,
  parameter int HOLD_CYC = 512,
  parameter int GAP_CYC  = 3,
  parameter logic [WORD_W-1:0] DEFAULT_CFG = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              host_en_strap,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] cfg_wdata,
  input  logic              pll_lock,
  input  logic              dll_lock,
  input  logic              dll_en,
  output logic              int_rst,
  output logic [WORD_W-1:0] cfg_word,
  output logic              cfg_valid,
  output logic              hard_rst,
  output logic              soft_rst
);
  front_t f_st_q;

  // Named internal events, visible to the bound checker.
  logic por_rise;
  logic load_default;
  logic wr_accept;
  logic word_done;
  logic seq_start;

  assign por_rise     = (f_st_q == F_IDLE) && por_n;
  assign load_default = por_rise && !host_en_strap;
  assign wr_accept    = (f_st_q == F_CFG) && cfg_wr;
  assign seq_start    = load_default || word_done;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      f_st_q <= F_IDLE;
    end else begin
      unique case (f_st_q)
        F_IDLE:  if (por_rise) f_st_q <= host_en_strap ? F_CFG : F_DONE;
        F_CFG:   if (word_done) f_st_q <= F_DONE;
        default: f_st_q <= F_DONE;
      endcase
    end
  end

  assign int_rst = (f_st_q != F_DONE);

  hcrs_cfg_loader #(
    .WORD_W(WORD_W),
    .BYTE_W(BYTE_W),
    .DEFAULT_CFG(DEFAULT_CFG)
  ) u_loader (
    .clk(clk),
    .por_n(por_n),
    .load_default(load_default),
    .wr_accept(wr_accept),
    .wr_data(cfg_wdata),
    .cfg_word(cfg_word),
    .cfg_valid(cfg_valid),
    .word_done(word_done)
  );

  hcrs_release_seq #(
    .DLL_WAIT(DLL_WAIT),
    .HOLD_CYC(HOLD_CYC),
    .GAP_CYC(GAP_CYC)
  ) u_seq (
    .clk(clk),
    .por_n(por_n),
    .start(seq_start),
    .pll_lock(pll_lock),
    .dll_lock(dll_lock),
    .dll_en(dll_en),
    .hard_rst(hard_rst),
    .soft_rst(soft_rst)
  );

endmodule

// File: rtl/hcrs_checker.sv
module hcrs_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              por_n,
  input logic              pll_lock,
  input logic              int_rst,
  input logic [WORD_W-1:0] cfg_word,
  input logic              cfg_valid,
  input logic              hard_rst,
  input logic              soft_rst,
  input logic              word_done
);

  p_reset_state_r1: assert property (@(posedge clk)
    !por_n |=> (int_rst && hard_rst && soft_rst && !cfg_valid && cfg_word == '0));

  p_release_needs_word_r3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(int_rst) |-> cfg_valid);

  p_valid_on_fourth_r4: assert property (@(posedge clk) disable iff (!por_n)
    word_done |=> cfg_valid);

  p_word_frozen_r5: assert property (@(posedge clk) disable iff (!por_n)
    cfg_valid |=> $stable(cfg_word));

  p_soft_covers_hard_r9: assert property (@(posedge clk) disable iff (!por_n)
    hard_rst |-> soft_rst);

  p_soft_gap_r9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(soft_rst) |-> (!$past(hard_rst, 1) && !$past(hard_rst, 3) && $past(hard_rst, 4)));

  p_release_needs_pll_r10: assert property (@(posedge clk) disable iff (!por_n)
    $fell(hard_rst) |-> $past(pll_lock));

  p_cfg_before_lock_r12: assert property (@(posedge clk) disable iff (!por_n)
    int_rst |-> hard_rst);

endmodule

bind hostcfg_reset_seq hcrs_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk),
  .por_n(por_n),
  .pll_lock(pll_lock),
  .int_rst(int_rst),
  .cfg_word(cfg_word),
  .cfg_valid(cfg_valid),
  .hard_rst(hard_rst),
  .soft_rst(soft_rst),
  .word_done(word_done)
);

// File: tb/hostcfg_reset_seq_bench.sv
module hostcfg_reset_seq_bench;
  localparam int DLL_CYC  = 3073;
  localparam int HOLD_CYC = 512;
  localparam int GAP_CYC  = 3;
  localparam logic [31:0] DEF_WORD = 32'h1234_ABCD;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        host_en_strap = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic        pll_lock = 1'b0;
  logic        dll_lock = 1'b0;
  logic        dll_en = 1'b0;
  logic        int_rst;
  logic [31:0] cfg_word;
  logic        cfg_valid;
  logic        hard_rst;
  logic        soft_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  hostcfg_reset_seq #(.DEFAULT_CFG(DEF_WORD)) u_hostcfg_reset_seq (
    .clk(clk), .por_n(por_n), .host_en_strap(host_en_strap),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pll_lock(pll_lock), .dll_lock(dll_lock), .dll_en(dll_en),
    .int_rst(int_rst), .cfg_word(cfg_word), .cfg_valid(cfg_valid),
    .hard_rst(hard_rst), .soft_rst(soft_rst)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic por_cycle(input logic strap);
    @(negedge clk);
    por_n = 1'b0; pll_lock = 1'b0; dll_lock = 1'b0; cfg_wr = 1'b0;
    host_en_strap = strap;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    cfg_wr = 1'b1; cfg_wdata = b;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Counts negedges from the current one; edge k is the k-th posedge after the call.
  task automatic measure(output int nh, output int ns);
    nh = -1; ns = -1;
    for (int k = 1; k <= 5000; k++) begin
      @(negedge clk);
      if (nh < 0 && !hard_rst) nh = k;
      if (ns < 0 && !soft_rst) ns = k;
      if (ns >= 0) break;
    end
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    wr(8'h5A);
    @(negedge clk);
    chk("R1 int_rst", 32'(int_rst), 32'd1);
    chk("R1 hard_rst", 32'(hard_rst), 32'd1);
    chk("R1 soft_rst", 32'(soft_rst), 32'd1);
    chk("R1 cfg_valid", 32'(cfg_valid), 32'd0);
    chk("R5 write during reset", cfg_word, 32'h0);
  endtask

  task automatic t_host_cfg();
    int nh, ns;
    dll_en = 1'b1;
    por_cycle(1'b1);
    host_en_strap = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 strap change ignored", 32'(int_rst), 32'd1);
    wr(8'h11); wr(8'h22); wr(8'h33);
    chk("R3 int_rst after three", 32'(int_rst), 32'd1);
    chk("R4 partial word", cfg_word, 32'h0033_2211);
    chk("R4 valid low", 32'(cfg_valid), 32'd0);
    wr(8'h44);
    chk("R3 int_rst after fourth", 32'(int_rst), 32'd0);
    chk("R4 full word", cfg_word, 32'h4433_2211);
    chk("R4 valid high", 32'(cfg_valid), 32'd1);
    wr(8'h99);
    chk("R5 fifth write ignored", cfg_word, 32'h4433_2211);
    pll_lock = 1'b1; dll_lock = 1'b1;
    measure(nh, ns);
    chk("R7 hard release dll on", 32'(nh), 32'(DLL_CYC + HOLD_CYC + 1));
    chk("R9 soft gap dll on", 32'(ns - nh), 32'(GAP_CYC));
  endtask

  task automatic t_strap_low();
    int nh, ns;
    dll_en = 1'b0;
    por_cycle(1'b0);
    chk("R6 int_rst released", 32'(int_rst), 32'd0);
    chk("R6 default word", cfg_word, DEF_WORD);
    chk("R6 valid", 32'(cfg_valid), 32'd1);
    host_en_strap = 1'b1;
    wr(8'h55);
    chk("R6 write ignored", cfg_word, DEF_WORD);
    chk("R2 strap change ignored", 32'(int_rst), 32'd0);
    pll_lock = 1'b1;
    measure(nh, ns);
    chk("R8 hard release dll off", 32'(nh), 32'(HOLD_CYC + 1));
    chk("R9 soft release dll off", 32'(ns), 32'(HOLD_CYC + GAP_CYC + 1));
  endtask

  task automatic t_pll_drop();
    int nh, ns;
    dll_en = 1'b1;
    por_cycle(1'b0);
    dll_lock = 1'b1; pll_lock = 1'b1;
    repeat (1000) @(negedge clk);
    chk("R10 hard before drop", 32'(hard_rst), 32'd1);
    pll_lock = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 hard during drop", 32'(hard_rst), 32'd1);
    pll_lock = 1'b1;
    measure(nh, ns);
    chk("R10 release from relock", 32'(nh), 32'(DLL_CYC + HOLD_CYC + 1));
  endtask

  task automatic t_dll_drop();
    int nh, ns;
    dll_en = 1'b1;
    por_cycle(1'b0);
    dll_lock = 1'b1; pll_lock = 1'b1;
    repeat (DLL_CYC + 100) @(negedge clk);
    chk("R11 hard in hold", 32'(hard_rst), 32'd1);
    dll_lock = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 hard during dll drop", 32'(hard_rst), 32'd1);
    dll_lock = 1'b1;
    measure(nh, ns);
    chk("R11 hold restarted", 32'(nh), 32'(HOLD_CYC + 1));
  endtask

  task automatic t_lock_early();
    int nh, ns;
    dll_en = 1'b0;
    por_cycle(1'b1);
    pll_lock = 1'b1;
    repeat (600) @(negedge clk);
    chk("R12 hard held in config", 32'(hard_rst), 32'd1);
    chk("R12 soft held in config", 32'(soft_rst), 32'd1);
    wr(8'hAA); wr(8'hBB); wr(8'hCC); wr(8'hDD);
    chk("R4 second word", cfg_word, 32'hDDCC_BBAA);
    measure(nh, ns);
    chk("R12 count from word done", 32'(nh), 32'(HOLD_CYC + 1));
  endtask

  task automatic t_por_mid();
    dll_en = 1'b0;
    por_cycle(1'b0);
    pll_lock = 1'b1;
    repeat (100) @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    chk("R1 mid int_rst", 32'(int_rst), 32'd1);
    chk("R1 mid hard_rst", 32'(hard_rst), 32'd1);
    chk("R1 mid soft_rst", 32'(soft_rst), 32'd1);
    chk("R1 mid valid", 32'(cfg_valid), 32'd0);
    chk("R1 mid word", cfg_word, 32'h0);
  endtask

  initial begin
    t_reset();
    t_host_cfg();
    t_strap_low();
    t_pll_drop();
    t_dll_drop();
    t_lock_early();
    t_por_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule